// File: doc/BRIEF.md
# Phase-Frequency Detector with Lead/Lag Override

This block compares a reference clock against the clock returned by a delay line and issues two charge-pump commands: UP (lengthen the line delay) and DN (shorten it). Both clocks are treated as level inputs sampled by a fast system clock `clk`. In normal operation a rising reference edge raises UP, a rising feedback edge raises DN, and once both are raised they stay high together for a fixed minimum number of fast cycles before clearing as a pair. Because a pending UP is not cancelled by further reference edges, the detector follows frequency errors as well as phase errors.

An external lock monitor steers the block through three inputs. While `lock_ok` is low, the `too_early` and `too_late` decisions drive the commands directly and the comparison state is held cleared. When `lock_ok` returns high, comparison restarts from the cleared state, so the first command after hand-back comes from a fresh clock edge and never from stale history.

Top module: `pfd_override`

## Requirements
- R1: While `lock_ok` is 0, `too_early`=1 with `too_late`=0 gives `up_cmd`=1, `dn_cmd`=0 in the same cycle, and `too_late`=1 with `too_early`=0 gives `up_cmd`=0, `dn_cmd`=1.
- R2: While `lock_ok` is 0, `up_cmd` and `dn_cmd` are never both 1; with `too_early` and `too_late` both 1 or both 0 both outputs are 0.
- R3: A clock edge seen with `lock_ok` at 0 clears the comparison state; after `lock_ok` returns to 1, both outputs stay 0 until a new rising edge of either clock arrives (a clock already high does not count).
- R4: While `lock_ok` is 0, activity on `ref_clk` and `fb_clk` has no effect on the outputs.
- R5: With `lock_ok` at 1, a 0-to-1 change of `ref_clk` sampled at one `clk` edge makes `up_cmd` 1 after that edge.
- R6: With `lock_ok` at 1, a 0-to-1 change of `fb_clk` sampled at one `clk` edge makes `dn_cmd` 1 after that edge.
- R7: Once both commands are 1 they stay 1 together for exactly `MIN_PULSE` cycles (default 2) and then clear together.
- R8: When the reference leads the feedback by d cycles, `up_cmd` is high for d+`MIN_PULSE` cycles and `dn_cmd` for `MIN_PULSE` cycles; with the feedback leading, the roles swap.
- R9: Further reference edges while `up_cmd` is pending keep it high, so with two reference edges before a feedback edge `up_cmd` spans from the first reference edge to `MIN_PULSE` cycles past the feedback edge.
- R10: While `rst_n` is 0 and `lock_ok` is 1, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Reference clock, sampled as a level |
| fb_clk | input | 1 | Delay-line output clock, sampled as a level |
| too_early | input | 1 | Lock monitor: line delay too short |
| too_late | input | 1 | Lock monitor: line delay too long |
| lock_ok | input | 1 | 1 = normal comparison, 0 = override |
| up_cmd | output | 1 | Command to lengthen the delay |
| dn_cmd | output | 1 | Command to shorten the delay |

## Verification
Override results are combinational, so the bench drives `too_early`, `too_late` and `lock_ok` just after a falling edge and reads the outputs a nanosecond later. A clock edge driven before a rising edge of `clk` shows on the outputs after that one edge, and pulse widths are counted by sampling at every falling edge across a fixed window, so a rise driven at step a is first seen at step a+1 and the paired clear lands `MIN_PULSE` steps after the later rise. Lead and lag offsets are swept from 0 to 10 cycles in both directions.

// File: rtl/pfd_pkg.sv
// Package: shared command type for the phase-frequency detector.
package pfd_pkg;
    typedef struct packed {
        logic up;   // lengthen delay
        logic dn;   // shorten delay
    } pfd_cmd_t;
endpackage

// File: rtl/pfd_edge_detect.sv
// Rising-edge detector for a level input sampled by clk.
// Assumes the input is already in the clk domain; flags the cycle in
// which the input is seen high after being low at the previous edge.
module pfd_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    // Remember the level seen at the previous clk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    // A rise is high now and low before.
    always_comb rise = level_in & ~level_q;
endmodule

// File: rtl/pfd_core.sv
// Comparison state of the detector: an UP and a DN flag set by clock
// rises and cleared as a pair after MIN_PULSE cycles of overlap.
// Assumes edge pulses are one cycle wide; edges arriving during the
// overlap window are absorbed by the clear.
module pfd_core #(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clear,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up_q,
    output logic dn_q
);
    localparam int CNT_W = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_PULSE - 1);

    logic [CNT_W-1:0] ovl_cnt;
    logic             both;

    always_comb both = up_q & dn_q;

    // Set flags on rises, clear both after the overlap window, or hold cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clear) begin
            up_q    <= 1'b0;
            dn_q    <= 1'b0;
            ovl_cnt <= '0;
        end else if (both) begin
            if (ovl_cnt == LAST) begin
                up_q    <= 1'b0;
                dn_q    <= 1'b0;
                ovl_cnt <= '0;
            end else begin
                ovl_cnt <= ovl_cnt + 1'b1;
            end
        end else begin
            if (ref_rise) up_q <= 1'b1;
            if (fb_rise)  dn_q <= 1'b1;
        end
    end

    // R3: a cycle in override leaves the state cleared.
    a_r3_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clear |=> (!up_q && !dn_q));
    // R5: a reference rise outside the overlap raises UP.
    a_r5_ref_sets_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_clear && ref_rise && !both) |=> up_q);
    // R6: a feedback rise outside the overlap raises DN.
    a_r6_fb_sets_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_clear && fb_rise && !both) |=> dn_q);
endmodule

// File: rtl/pfd_cmd_mux.sv
// Output steering: detector flags in normal mode, lock-monitor
// decisions in override mode. Conflicting decisions give no command.
module pfd_cmd_mux
    import pfd_pkg::*;
(
    input  logic     use_core,
    input  pfd_cmd_t core_cmd,
    input  logic     early,
    input  logic     late,
    output pfd_cmd_t out_cmd
);
    pfd_cmd_t ovr_cmd;

    // Translate the monitor decisions into exclusive commands.
    always_comb begin
        ovr_cmd.up = early & ~late;
        ovr_cmd.dn = late & ~early;
    end

    // Choose the command source.
    always_comb out_cmd = use_core ? core_cmd : ovr_cmd;
endmodule

// File: rtl/pfd_override.sv
// Top: phase-frequency detector with a lock-monitor override path.
// Assumes ref_clk and fb_clk are sampled levels in the clk domain and
// that clk is several times faster than ref_clk.
module pfd_override
    import pfd_pkg::*;
#(
    parameter int MIN_PULSE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic fb_clk,
    input  logic too_early,
    input  logic too_late,
    input  logic lock_ok,
    output logic up_cmd,
    output logic dn_cmd
);
    logic     ref_rise, fb_rise;
    pfd_cmd_t core_cmd, sel_cmd;

    pfd_edge_detect i_ref_edge (.clk(clk), .rst_n(rst_n), .level_in(ref_clk), .rise(ref_rise));
    pfd_edge_detect i_fb_edge  (.clk(clk), .rst_n(rst_n), .level_in(fb_clk),  .rise(fb_rise));

    pfd_core #(.MIN_PULSE(MIN_PULSE)) i_core (
        .clk(clk), .rst_n(rst_n), .hold_clear(~lock_ok),
        .ref_rise(ref_rise), .fb_rise(fb_rise),
        .up_q(core_cmd.up), .dn_q(core_cmd.dn)
    );

    pfd_cmd_mux i_mux (
        .use_core(lock_ok), .core_cmd(core_cmd),
        .early(too_early), .late(too_late), .out_cmd(sel_cmd)
    );

    // Drive the ports from the selected command.
    always_comb begin
        up_cmd = sel_cmd.up;
        dn_cmd = sel_cmd.dn;
    end

    // R2: override never asks for both directions.
    a_r2_override_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ok |-> !(up_cmd && dn_cmd));
    // R1: an early decision in override lengthens the delay.
    a_r1_early_gives_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_ok && too_early && !too_late) |-> (up_cmd && !dn_cmd));
    // R1: a late decision in override shortens the delay.
    a_r1_late_gives_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_ok && too_late && !too_early) |-> (dn_cmd && !up_cmd));
endmodule

// File: tb/test_pfd_override.sv
module test_pfd_override;
    logic clk = 1'b0;
    logic rst_n, ref_clk, fb_clk, too_early, too_late, lock_ok;
    logic up_cmd, dn_cmd;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    localparam int MINP = 2;

    always #4 clk = ~clk;

    pfd_override #(.MIN_PULSE(MINP)) i_pfd_override (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .fb_clk(fb_clk),
        .too_early(too_early), .too_late(too_late), .lock_ok(lock_ok),
        .up_cmd(up_cmd), .dn_cmd(dn_cmd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_clk = 1'b0; fb_clk = 1'b0;
        end
    endtask

    // One lead/lag trial: ref rises at step tr, fb at step tf.
    task automatic phase_trial(input int tr, input int tf);
        int up_w = 0, dn_w = 0;
        int first = (tr < tf) ? tr : tf;
        int d = (tr < tf) ? tf - tr : tr - tf;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            up_w += int'(up_cmd);
            dn_w += int'(dn_cmd);
            if (i == first + 1) begin
                if (tr <= tf) chk(up_cmd == 1'b1, "R5 up after ref rise", int'(up_cmd), 1);
                if (tf <= tr) chk(dn_cmd == 1'b1, "R6 dn after fb rise", int'(dn_cmd), 1);
            end
            ref_clk = (i >= tr);
            fb_clk  = (i >= tf);
        end
        chk(up_w == ((tr <= tf) ? d + MINP : MINP), "R8 up width", up_w, (tr <= tf) ? d + MINP : MINP);
        chk(dn_w == ((tf <= tr) ? d + MINP : MINP), "R8 dn width", dn_w, (tf <= tr) ? d + MINP : MINP);
        idle(4);
    endtask

    initial begin
        #200000;
        chk(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        rst_n = 1'b0; ref_clk = 1'b0; fb_clk = 1'b0;
        too_early = 1'b0; too_late = 1'b0; lock_ok = 1'b1;
        // R10: outputs low during reset, even with clock rises.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!up_cmd && !dn_cmd, "R10 reset outputs", int'(up_cmd) + int'(dn_cmd), 0);
            ref_clk = i[0]; fb_clk = ~i[0];
        end
        @(negedge clk); ref_clk = 1'b0; fb_clk = 1'b0;
        rst_n = 1'b1;
        idle(3);

        // R7: simultaneous rises give a paired pulse of MINP cycles.
        phase_trial(0, 0);
        // R8: sweep lead and lag offsets.
        for (int d = 1; d <= 10; d++) begin
            phase_trial(0, d);
            phase_trial(d, 0);
        end

        // R9: two reference rises before one feedback rise.
        begin
            int up_w = 0, dn_w = 0;
            for (int i = 0; i < 24; i++) begin
                @(negedge clk);
                up_w += int'(up_cmd);
                dn_w += int'(dn_cmd);
                ref_clk = (i < 2) || (i >= 4);
                fb_clk  = (i >= 7);
            end
            chk(up_w == 7 + MINP, "R9 up spans two ref edges", up_w, 7 + MINP);
            chk(dn_w == MINP, "R9 dn width", dn_w, MINP);
            idle(4);
        end

        // R3: drop lock mid-pulse, return with ref held high.
        @(negedge clk); ref_clk = 1'b1;
        @(negedge clk);
        chk(up_cmd == 1'b1, "R5 up before override", int'(up_cmd), 1);
        lock_ok = 1'b0;
        #1 chk(!up_cmd && !dn_cmd, "R3 override idle outputs", int'(up_cmd) + int'(dn_cmd), 0);
        idle(0);
        for (int i = 0; i < 3; i++) @(negedge clk);
        lock_ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!up_cmd && !dn_cmd, "R3 no stale command after lock", int'(up_cmd) + int'(dn_cmd), 0);
        end
        ref_clk = 1'b0;
        idle(3);

        // R1 R2 R4: override truth table while clocks toggle.
        lock_ok = 1'b0;
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                too_early = c[0]; too_late = c[1];
                ref_clk = i[0]; fb_clk = i[1];
                #1;
                chk(up_cmd == (c == 1), "R1 R4 up in override", int'(up_cmd), int'(c == 1));
                chk(dn_cmd == (c == 2), "R1 R4 dn in override", int'(dn_cmd), int'(c == 2));
                if (c == 3)
                    chk(!(up_cmd && dn_cmd), "R2 exclusive override", int'(up_cmd) + int'(dn_cmd), 0);
            end
        end
        @(negedge clk);
        too_early = 1'b0; too_late = 1'b0; ref_clk = 1'b0; fb_clk = 1'b0;
        lock_ok = 1'b1;
        idle(3);
        // Normal tracking resumes after override.
        phase_trial(0, 3);
        report();
    end
endmodule